// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes for a multiplexed external memory bus of an 8-bit microcontroller core. It counts oscillator clocks through a machine cycle of twelve phases and, per cycle, decides what kind of bus activity takes place: internal execution, an external code fetch, or a data read or data write to external memory. From the phase and the cycle kind it decodes the address latch strobe, the active-low code read strobe, the active-low data read and data write strobes, and the selection of the byte placed on the upper address port.

The core presents its wishes for the next machine cycle on level inputs: an external-fetch flag, a data-access request with direction and address width, and a control bit that silences the address latch strobe in cycles that use no external bus. These inputs are sampled once, at the clock edge that closes the last phase of a cycle, so mid-cycle changes cannot tear a bus cycle apart. The upper-address selection also drives a byte mux between the address high byte and the port register value.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is asserted and until the cycle counter starts, the cycle kind is internal execution at phase 0: the latch strobe is high, all three active-low strobes are high, the upper-byte select is 0 and the port output carries the port register value. The counter advances from the third rising edge after reset is released.
- R2: In internal and external-fetch cycles with the quiet bit clear, the latch strobe is high in phases 0-1 and 6-7 of each 12-phase cycle and low otherwise, i.e. two pulses per cycle at one sixth of the clock rate.
- R3: In a data read or data write cycle, the latch strobe is high only in phases 0-1; the pulse in phases 6-7 is skipped.
- R4: With the quiet bit set, internal cycles have no latch pulse at all, while external-fetch cycles keep both pulses and data cycles keep their single pulse.
- R5: In an external-fetch cycle the code read strobe is low in phases 3-5 and 9-11.
- R6: The code read strobe stays high for the whole of a data cycle (both activations dropped) and of an internal cycle.
- R7: In a data read cycle the data read strobe is low in phases 3-10 and the data write strobe stays high; a data write cycle is the mirror. Both are never low together.
- R8: Whenever any of the three active-low strobes is low, the latch strobe is low.
- R9: The cycle kind is taken from the inputs at the rising edge that ends phase 11; a data request has priority over an external fetch; input changes at any other edge have no effect on the current cycle.
- R10: The upper-byte select is 1 (port output equals the address high byte) in external-fetch cycles and in data cycles requested with the wide flag, and 0 (port output equals the port register value) in narrow data cycles and internal cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fetch_i | input | 1 | Next cycle fetches code from external memory |
| xdata_req_i | input | 1 | Next cycle is an external data access |
| xdata_wr_i | input | 1 | Data access direction, 1 = write |
| xdata_wide_i | input | 1 | Data access uses a 16-bit address |
| ale_quiet_i | input | 1 | Silence the latch strobe in internal cycles |
| addr_hi_i | input | HI_W | Address high byte |
| port_reg_i | input | HI_W | Upper port register value |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Code read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| hi_sel_o | output | 1 | 1 = address high byte on the upper port |
| port_hi_o | output | HI_W | Byte driven on the upper port |

## Verification
All outputs are decoded without a register from the phase counter and the latched cycle kind, so each one is due in the same clock period as the phase it belongs to; an input presented before the edge that closes phase 11 shows its effect from phase 0, one edge later, and the upper-port byte follows its data inputs at once. After reset release the first phase advance comes on the third rising edge. The bench keeps its own phase and kind, updated on the rising edge, and compares every output on every falling edge, when both design and model have settled, including a long stretch of inputs that change on every clock.

// File: rtl/bstrobe_pkg.sv
`timescale 1ns/1ps
package bstrobe_pkg;

  typedef enum logic [1:0] {
    CYC_INT   = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_DRD   = 2'd2,
    CYC_DWR   = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      wide;
    logic      quiet;
  } cyc_ctl_t;

endpackage

// File: rtl/bstrobe_rst_sync.sv
`timescale 1ns/1ps
module bstrobe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/bstrobe_phase.sv
`timescale 1ns/1ps
module bstrobe_phase #(
  parameter int CYC_LEN = 12,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [PW-1:0] P_LAST = PW'(CYC_LEN - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    last_o  = (phase_q == P_LAST);
    phase_d = last_o ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bstrobe_cycle_ctl.sv
`timescale 1ns/1ps
module bstrobe_cycle_ctl
  import bstrobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_i,
  input  logic     ext_fetch_i,
  input  logic     xdata_req_i,
  input  logic     xdata_wr_i,
  input  logic     xdata_wide_i,
  input  logic     ale_quiet_i,
  output cyc_ctl_t ctl_o
);
  cyc_ctl_t ctl_q;
  cyc_ctl_t ctl_d;

  always_comb begin
    ctl_d       = ctl_q;
    ctl_d.quiet = ale_quiet_i;
    ctl_d.wide  = xdata_req_i & xdata_wide_i;
    if (xdata_req_i)      ctl_d.kind = xdata_wr_i ? CYC_DWR : CYC_DRD;
    else if (ext_fetch_i) ctl_d.kind = CYC_FETCH;
    else                  ctl_d.kind = CYC_INT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.kind  <= CYC_INT;
      ctl_q.wide  <= 1'b0;
      ctl_q.quiet <= 1'b0;
    end else if (adv_i) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/bstrobe_decode.sv
`timescale 1ns/1ps
module bstrobe_decode
  import bstrobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic [PW-1:0] phase_i,
  input  cyc_ctl_t      ctl_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          hi_sel_o
);
  localparam logic [PW-1:0] P_HALF  = PW'(CYC_LEN / 2);
  localparam logic [PW-1:0] P_ALE_B = PW'(CYC_LEN / 2 + ALE_W);
  localparam logic [PW-1:0] P_STR   = PW'(ALE_W + 1);
  localparam logic [PW-1:0] P_STR_B = PW'(CYC_LEN / 2 + ALE_W + 1);
  localparam logic [PW-1:0] P_DEND  = PW'(CYC_LEN - 2);
  localparam logic [PW-1:0] P_ALE_W = PW'(ALE_W);

  logic slot_a, slot_b, code_a, code_b, data_win;

  always_comb begin
    slot_a   = (phase_i < P_ALE_W);
    slot_b   = (phase_i >= P_HALF) && (phase_i < P_ALE_B);
    code_a   = (phase_i >= P_STR) && (phase_i < P_HALF);
    code_b   = (phase_i >= P_STR_B);
    data_win = (phase_i >= P_STR) && (phase_i <= P_DEND);
  end

  always_comb begin
    ale_o    = 1'b0;
    psen_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    hi_sel_o = 1'b0;
    unique case (ctl_i.kind)
      CYC_INT: begin
        ale_o = ~ctl_i.quiet & (slot_a | slot_b);
      end
      CYC_FETCH: begin
        ale_o    = slot_a | slot_b;
        psen_n_o = ~(code_a | code_b);
        hi_sel_o = 1'b1;
      end
      CYC_DRD: begin
        ale_o    = slot_a;
        rd_n_o   = ~data_win;
        hi_sel_o = ctl_i.wide;
      end
      CYC_DWR: begin
        ale_o    = slot_a;
        wr_n_o   = ~data_win;
        hi_sel_o = ctl_i.wide;
      end
      default: ale_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen
  import bstrobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int HI_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_fetch_i,
  input  logic            xdata_req_i,
  input  logic            xdata_wr_i,
  input  logic            xdata_wide_i,
  input  logic            ale_quiet_i,
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic [HI_W-1:0] port_reg_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic            hi_sel_o,
  output logic [HI_W-1:0] port_hi_o
);
  localparam int PW = $clog2(CYC_LEN);

  logic          rst_sync_n;
  logic [PW-1:0] phase;
  logic          last_phase;
  cyc_ctl_t      ctl;
  logic [1:0]    ctl_kind;

  bstrobe_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bstrobe_phase #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .phase_o (phase),
    .last_o  (last_phase)
  );

  bstrobe_cycle_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .adv_i        (last_phase),
    .ext_fetch_i  (ext_fetch_i),
    .xdata_req_i  (xdata_req_i),
    .xdata_wr_i   (xdata_wr_i),
    .xdata_wide_i (xdata_wide_i),
    .ale_quiet_i  (ale_quiet_i),
    .ctl_o        (ctl)
  );

  bstrobe_decode #(.CYC_LEN(CYC_LEN), .ALE_W(ALE_W)) u_dec (
    .phase_i  (phase),
    .ctl_i    (ctl),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .hi_sel_o (hi_sel_o)
  );

  assign ctl_kind = ctl.kind;

  for (genvar b = 0; b < HI_W; b++) begin : g_port_mux
    assign port_hi_o[b] = hi_sel_o ? addr_hi_i[b] : port_reg_i[b];
  end
endmodule

// File: rtl/bus_strobe_gen_chk.sv
`timescale 1ns/1ps
module bus_strobe_gen_chk #(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  localparam int PW = $clog2(CYC_LEN)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [PW-1:0] phase_i,
  input logic [1:0]    kind_i,
  input logic          ale_o,
  input logic          psen_n_o,
  input logic          rd_n_o,
  input logic          wr_n_o
);
  localparam logic [PW-1:0] P_HALF = PW'(CYC_LEN / 2);
  localparam logic [PW-1:0] P_STR  = PW'(ALE_W + 1);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!rd_n_o && !wr_n_o));

  assert_rd_start_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(rd_n_o) |-> (phase_i == P_STR));

  assert_ale_low_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!psen_n_o || !rd_n_o || !wr_n_o) |-> !ale_o);

  assert_code_off_in_data_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_n_o || !wr_n_o) |-> psen_n_o);

  assert_kind_held_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_i != '0) |-> $stable(kind_i));

  assert_ale_rise_slot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ale_o) |-> (phase_i == '0 || phase_i == P_HALF));

  assert_no_second_ale_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kind_i[1] && phase_i >= P_HALF) |-> !ale_o);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.CYC_LEN(CYC_LEN), .ALE_W(ALE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .phase_i    (phase),
  .kind_i     (ctl_kind),
  .ale_o      (ale_o),
  .psen_n_o   (psen_n_o),
  .rd_n_o     (rd_n_o),
  .wr_n_o     (wr_n_o)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_fetch, xreq, xwr, xwide, quiet;
  logic [7:0] addr_hi, port_reg;
  logic       ale, psen_n, rd_n, wr_n, hi_sel;
  logic [7:0] port_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  bus_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .ext_fetch_i(ext_fetch), .xdata_req_i(xreq),
    .xdata_wr_i(xwr), .xdata_wide_i(xwide), .ale_quiet_i(quiet),
    .addr_hi_i(addr_hi), .port_reg_i(port_reg), .ale_o(ale), .psen_n_o(psen_n),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .hi_sel_o(hi_sel), .port_hi_o(port_hi)
  );

  // Reference model: kind 0 internal, 1 fetch, 2 data read, 3 data write
  int m_ph, m_kind, m_wide, m_quiet, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_kind = 0; m_wide = 0; m_quiet = 0; m_cnt = 0;
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      if (m_ph == 11) begin
        if (xreq)           m_kind = xwr ? 3 : 2;
        else if (ext_fetch) m_kind = 1;
        else                m_kind = 0;
        m_wide  = (xreq && xwide) ? 1 : 0;
        m_quiet = quiet ? 1 : 0;
      end
      m_ph = (m_ph + 1) % 12;
    end
  end

  task automatic cmp(string tag, string ctx, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] phase %0d kind %0d: got %b expected %b", tag, ctx, m_ph, m_kind, act, exp);
    end
  endtask

  task automatic check_now(string ctx);
    logic e_ale, e_psen, e_rd, e_wr, e_hi;
    logic [7:0] e_port;
    string atag;
    if (m_ph <= 1)                    e_ale = (m_kind != 0) || (m_quiet == 0);
    else if (m_ph == 6 || m_ph == 7)  e_ale = (m_kind == 1) || (m_kind == 0 && m_quiet == 0);
    else                              e_ale = 1'b0;
    e_psen = !(m_kind == 1 && ((m_ph >= 3 && m_ph <= 5) || m_ph >= 9));
    e_rd   = !(m_kind == 2 && m_ph >= 3 && m_ph <= 10);
    e_wr   = !(m_kind == 3 && m_ph >= 3 && m_ph <= 10);
    e_hi   = (m_kind == 1) || (m_kind >= 2 && m_wide == 1);
    e_port = e_hi ? addr_hi : port_reg;
    atag = (m_kind >= 2) ? "R3" : ((m_kind == 0 && m_quiet == 1) ? "R4" : "R2");
    cmp(atag, ctx, ale, e_ale);
    cmp((m_kind == 1) ? "R5" : "R6", ctx, psen_n, e_psen);
    cmp("R7", ctx, rd_n, e_rd);
    cmp("R7", ctx, wr_n, e_wr);
    cmp("R10", ctx, hi_sel, e_hi);
    n_checks++;
    if (port_hi !== e_port) begin
      n_fail++;
      $display("FAIL R10 [%s] port byte got %h expected %h", ctx, port_hi, e_port);
    end
    // R8: latch strobe must be low while any strobe is active
    n_checks++;
    if ((!psen_n || !rd_n || !wr_n) && ale) begin
      n_fail++;
      $display("FAIL R8 [%s] ale=%b with strobes psen=%b rd=%b wr=%b expected ale 0", ctx, ale, psen_n, rd_n, wr_n);
    end
  endtask

  task automatic run(int n, string ctx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now(ctx);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; ext_fetch = 0; xreq = 0; xwr = 0; xwide = 0; quiet = 0;
    addr_hi = 8'hA5; port_reg = 8'h3C;
    run(3, "R1 reset");
    // R1: explicit reset values
    cmp("R1", "reset ale", ale, 1'b1);
    cmp("R1", "reset psen", psen_n, 1'b1);
    cmp("R1", "reset hi_sel", hi_sel, 1'b0);
    rst_n = 1'b1;
    run(3, "R1 release");
    run(24, "R2 internal");
    ext_fetch = 1;
    run(36, "R5 external fetch");
    xreq = 1; xwr = 0; xwide = 1;
    run(24, "R3 data read wide, R9 priority");
    xwr = 1; xwide = 0; port_reg = 8'h5A;
    run(24, "R7 data write narrow");
    xreq = 0; ext_fetch = 0; quiet = 1;
    run(24, "R4 quiet internal");
    ext_fetch = 1;
    run(24, "R4 quiet fetch");
    xreq = 1; xwr = 0;
    run(24, "R4 quiet data");
    for (int k = 0; k < 600; k++) begin
      run(1, "R9 random inputs");
      {ext_fetch, xreq, xwr, xwide, quiet} = 5'($urandom);
      addr_hi  = 8'($urandom);
      port_reg = 8'($urandom);
    end
    rst_n = 1'b0;
    run(2, "R1 second reset");
    rst_n = 1'b1; xreq = 0; ext_fetch = 1; quiet = 0;
    run(30, "R1 restart");
    summary();
  end
endmodule